// File: doc/BRIEF.md
# Shared Cache Maintenance Command Queue

This block sits in front of an outer cache and accepts maintenance work (invalidate, clean, flush) from several processors over one register bus. Each bus access carries the identifier of the processor making it. A command covers either an address window or the whole cache. A processor builds a command in a small set of shared staging registers. A hardware lock guards those registers: the first processor to write the mode register owns them until it reads its own registration status.

Accepted commands enter a four-entry first-in first-out queue, and each entry is tagged with the identifier of the processor that issued it. A single executor takes one entry at a time. It announces the entry on a command port toward the cache and holds it for a fixed number of cycles before retiring it. Every processor sees its own registration failures, its own pending and executing state, and its own completion flag. A separate primitive register accepts a drain request and a prefetch-buffer flush request.

Top module: `cache_maint_queue`

## Requirements
- R1: After reset the queue is empty, the lock is free, every per-processor status register reads 0, the primitive register reads 0, and cmd_valid, sync_done and pf_flush are low.
- R2: The mode register (offset 0x00) carries the operation in bits 1:0 (0 invalidate, 1 clean, 2 flush), the scope in bits 18:17 (0 address window, 1 whole cache) and a completion-notify request in bit 15. A mode write with operation 3 or with bit 18 set is rejected. A rejected write sets the fail bit of the writer and stages nothing.
- R3: A whole-cache command is committed by its mode write and is issued with cmd_all=1, cmd_start=0 and cmd_size=0. A window command is committed by the owner's write to the size register (offset 0x08). Before that write, the start register (offset 0x04) may be written. The command is issued with both values.
- R4: An accepted mode write claims the staging lock for the writer. Only a read of the registration status by the owner releases it. While the lock is held, mode, start or size writes from any other processor change nothing and set that processor's fail bit. Their status reads do not release the lock.
- R5: The registration status (offset 0x0C, read) returns bit 1 = queue full and bit 0 = failed registration for the reading processor, and clears both bits. If the owner reads it while a window command still awaits its size write, the read returns bit 0 set and the staged command is dropped.
- R6: A command committed while the queue already holds 4 entries is dropped, and bit 1 of the committer's registration status is set.
- R7: Entries execute one at a time, in arrival order. Each issue is a one-cycle cmd_valid pulse. While entries are waiting, consecutive pulses are LATENCY+1 cycles apart.
- R8: The queue status (offset 0x10, read) returns, for the reader, bit 0 = it has a queued or executing entry, bit 1 = its entry is executing, and bit 2 = end flag. The end flag is set at retirement, only for the issuing processor, and only if that command asked for notify. A write with bit 2 set clears the writer's end flag; the other bits of the write are ignored.
- R9: Writing 0x8 to the primitive register (offset 0x14) starts a drain. The register then reads bit 0 = 1 until the queue is empty and the executor idle, and a one-cycle sync_done pulse marks the end of the drain. Writing 0x9 gives a one-cycle pf_flush pulse. Any other value has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_cpu | input | CW | Identifier of the accessing processor |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| cmd_valid | output | 1 | One-cycle pulse issuing a command |
| cmd_op | output | 2 | Operation of the issued command |
| cmd_all | output | 1 | Issued command covers the whole cache |
| cmd_start | output | AW | Window start address |
| cmd_size | output | AW | Window size |
| cmd_cpu | output | CW | Processor that issued the command |
| sync_done | output | 1 | Pulse when a drain finishes |
| pf_flush | output | 1 | Pulse requesting a prefetch-buffer flush |

## Verification
The bench builds the block with two processors, a four-entry queue and LATENCY=30. With that latency the executor stays busy long enough for the bench to fill all four slots from a single processor using ordinary two-cycle bus accesses, so the queue-full path and the 31-cycle issue spacing can be reached. The two processors make lock contention, per-processor isolation of flags, and lock release by the owner's status read all observable at the ports.

// File: rtl/cache_maint_queue.sv
module cache_maint_queue #(
  parameter int NCPU    = 2,
  parameter int DEPTH   = 4,
  parameter int LATENCY = 8,
  parameter int AW      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [((NCPU>1)?$clog2(NCPU):1)-1:0] bus_cpu,
  input  logic [5:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 cmd_valid,
  output logic [1:0]           cmd_op,
  output logic                 cmd_all,
  output logic [AW-1:0]        cmd_start,
  output logic [AW-1:0]        cmd_size,
  output logic [((NCPU>1)?$clog2(NCPU):1)-1:0] cmd_cpu,
  output logic                 sync_done,
  output logic                 pf_flush
);
  localparam int CW   = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = PW + 1;
  localparam int LW   = $clog2(LATENCY + 1);
  localparam logic [5:0] A_MODE  = 6'h00;
  localparam logic [5:0] A_START = 6'h04;
  localparam logic [5:0] A_SIZE  = 6'h08;
  localparam logic [5:0] A_REGST = 6'h0C;
  localparam logic [5:0] A_QST   = 6'h10;
  localparam logic [5:0] A_PRIM  = 6'h14;

  logic          lock_held, stg_armed, stg_ntf;
  logic [CW-1:0] lock_cpu;
  logic [1:0]    stg_op;
  logic [AW-1:0] stg_start;
  logic [NCPU-1:0] fail_f, full_f, ef, pend;

  logic [CW-1:0] q_cpu   [DEPTH];
  logic [1:0]    q_op    [DEPTH];
  logic          q_all   [DEPTH];
  logic          q_ntf   [DEPTH];
  logic [AW-1:0] q_start [DEPTH];
  logic [AW-1:0] q_size  [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;

  logic          busy, ex_ntf, sync_pend;
  logic [LW-1:0] lat_cnt;
  logic [CW-1:0] ex_cpu;

  logic cpu_ok, acc_wr, acc_rd, is_owner, foreign, mode_good;
  logic wr_mode, wr_start, wr_size, wr_qst, wr_prim, rd_regst;
  logic commit, push, pop, retire, full;
  logic [1:0]    cm_op;
  logic          cm_all, cm_ntf;
  logic [AW-1:0] cm_start, cm_size;
  logic [31:0]   rd_val;

  assign cpu_ok    = int'(bus_cpu) < NCPU;
  assign acc_wr    = bus_valid & bus_write & cpu_ok;
  assign acc_rd    = bus_valid & ~bus_write & cpu_ok;
  assign is_owner  = lock_held & (lock_cpu == bus_cpu);
  assign foreign   = lock_held & ~is_owner;
  assign mode_good = (bus_wdata[1:0] != 2'd3) & ~bus_wdata[18];

  assign wr_mode  = acc_wr & (bus_addr == A_MODE);
  assign wr_start = acc_wr & (bus_addr == A_START);
  assign wr_size  = acc_wr & (bus_addr == A_SIZE);
  assign wr_qst   = acc_wr & (bus_addr == A_QST);
  assign wr_prim  = acc_wr & (bus_addr == A_PRIM);
  assign rd_regst = acc_rd & (bus_addr == A_REGST);

  assign commit = (wr_mode & ~foreign & mode_good & bus_wdata[17])
                | (wr_size & is_owner & stg_armed);
  assign cm_op    = wr_mode ? bus_wdata[1:0] : stg_op;
  assign cm_all   = wr_mode;
  assign cm_ntf   = wr_mode ? bus_wdata[15] : stg_ntf;
  assign cm_start = wr_mode ? '0 : stg_start;
  assign cm_size  = wr_mode ? '0 : AW'(bus_wdata);

  assign full   = (count == CNTW'(DEPTH));
  assign push   = commit & ~full;
  assign pop    = ~busy & (count != '0);
  assign retire = busy & (lat_cnt == LW'(1));

  always_comb begin
    pend = '0;
    for (int k = 0; k < DEPTH; k++)
      if (CNTW'(k) < count) pend[q_cpu[rd_ptr + PW'(k)]] = 1'b1;
    if (busy) pend[ex_cpu] = 1'b1;
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      A_REGST: rd_val = {30'd0, full_f[bus_cpu], fail_f[bus_cpu] | (is_owner & stg_armed)};
      A_QST:   rd_val = {29'd0, ef[bus_cpu], busy & (ex_cpu == bus_cpu), pend[bus_cpu]};
      A_PRIM:  rd_val = {31'd0, sync_pend};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_cpu[wr_ptr]   <= bus_cpu;
      q_op[wr_ptr]    <= cm_op;
      q_all[wr_ptr]   <= cm_all;
      q_ntf[wr_ptr]   <= cm_ntf;
      q_start[wr_ptr] <= cm_start;
      q_size[wr_ptr]  <= cm_size;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_held <= 1'b0;
      lock_cpu  <= '0;
      stg_armed <= 1'b0;
      stg_ntf   <= 1'b0;
      stg_op    <= '0;
      stg_start <= '0;
      fail_f    <= '0;
      full_f    <= '0;
      ef        <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      busy      <= 1'b0;
      lat_cnt   <= '0;
      ex_cpu    <= '0;
      ex_ntf    <= 1'b0;
      sync_pend <= 1'b0;
      sync_done <= 1'b0;
      pf_flush  <= 1'b0;
      bus_rdata <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_all   <= 1'b0;
      cmd_start <= '0;
      cmd_size  <= '0;
      cmd_cpu   <= '0;
    end else begin
      cmd_valid <= 1'b0;
      sync_done <= 1'b0;
      pf_flush  <= wr_prim & (bus_wdata == 32'h9);

      if (acc_rd) bus_rdata <= rd_val;

      if (wr_mode) begin
        if (foreign || !mode_good) begin
          fail_f[bus_cpu] <= 1'b1;
        end else begin
          lock_held <= 1'b1;
          lock_cpu  <= bus_cpu;
          stg_op    <= bus_wdata[1:0];
          stg_ntf   <= bus_wdata[15];
          stg_start <= '0;
          stg_armed <= ~bus_wdata[17];
        end
      end
      if (wr_start) begin
        if (is_owner && stg_armed) stg_start <= AW'(bus_wdata);
        else fail_f[bus_cpu] <= 1'b1;
      end
      if (wr_size) begin
        if (is_owner && stg_armed) stg_armed <= 1'b0;
        else fail_f[bus_cpu] <= 1'b1;
      end
      if (commit && full) full_f[bus_cpu] <= 1'b1;
      if (rd_regst) begin
        fail_f[bus_cpu] <= 1'b0;
        full_f[bus_cpu] <= 1'b0;
        if (is_owner) begin
          lock_held <= 1'b0;
          stg_armed <= 1'b0;
        end
      end

      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNTW'(push) - CNTW'(pop);

      if (pop) begin
        busy      <= 1'b1;
        lat_cnt   <= LW'(LATENCY);
        ex_cpu    <= q_cpu[rd_ptr];
        ex_ntf    <= q_ntf[rd_ptr];
        cmd_valid <= 1'b1;
        cmd_op    <= q_op[rd_ptr];
        cmd_all   <= q_all[rd_ptr];
        cmd_start <= q_start[rd_ptr];
        cmd_size  <= q_size[rd_ptr];
        cmd_cpu   <= q_cpu[rd_ptr];
      end else if (retire) begin
        busy <= 1'b0;
      end else if (busy) begin
        lat_cnt <= lat_cnt - 1'b1;
      end

      if (wr_qst && bus_wdata[2]) ef[bus_cpu] <= 1'b0;
      if (retire && ex_ntf) ef[ex_cpu] <= 1'b1;

      if (wr_prim && bus_wdata == 32'h8) begin
        sync_pend <= 1'b1;
      end else if (sync_pend && count == '0 && !busy) begin
        sync_pend <= 1'b0;
        sync_done <= 1'b1;
      end
    end
  end

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));

  // R4
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_held && bus_valid && bus_cpu != lock_cpu) |=> (lock_held && $stable(lock_cpu)));

  // R7
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R7
  cmd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(count) != '0);

  // R9
  sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> $past(count == '0 && !busy));

  for (genvar g = 0; g < NCPU; g++) begin : g_ef
    // R8
    ef_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ef[g]) |-> $past(busy && lat_cnt == LW'(1) && ex_ntf && ex_cpu == CW'(g)));
  end
endmodule

// File: tb/cache_maint_queue_test.sv
`timescale 1ns/1ps
module cache_maint_queue_test;
  localparam int LAT = 30;
  localparam logic [5:0] A_MODE = 6'h00, A_START = 6'h04, A_SIZE = 6'h08;
  localparam logic [5:0] A_REGST = 6'h0C, A_QST = 6'h10, A_PRIM = 6'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [0:0] bus_cpu = '0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cmd_valid, cmd_all, sync_done, pf_flush;
  logic [1:0] cmd_op;
  logic [31:0] cmd_start, cmd_size;
  logic [0:0] cmd_cpu;

  int checks = 0, failures = 0, cyc = 0, ncmd = 0, nsync = 0, npf = 0;
  logic done = 1'b0;
  logic [1:0]  m_op [32];
  logic        m_all [32];
  logic [0:0]  m_cpu [32];
  logic [31:0] m_start [32], m_size [32];
  int          m_cyc [32];

  cache_maint_queue #(.NCPU(2), .DEPTH(4), .LATENCY(LAT), .AW(32)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_all(cmd_all), .cmd_start(cmd_start),
    .cmd_size(cmd_size), .cmd_cpu(cmd_cpu), .sync_done(sync_done), .pf_flush(pf_flush));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid && ncmd < 32) begin
      m_op[ncmd] = cmd_op; m_all[ncmd] = cmd_all; m_cpu[ncmd] = cmd_cpu;
      m_start[ncmd] = cmd_start; m_size[ncmd] = cmd_size; m_cyc[ncmd] = cyc;
      ncmd++;
    end
    if (sync_done) nsync++;
    if (pf_flush) npf++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int c, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_cpu = c[0]; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input int c, input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = c[0]; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, A_QST, v);   check("R1 qstat cpu0", v, 0);
    rd(1, A_QST, v);   check("R1 qstat cpu1", v, 0);
    rd(0, A_REGST, v); check("R1 regstat", v, 0);
    rd(1, A_PRIM, v);  check("R1 prim", v, 0);
    check("R1 no outputs", {ncmd[7:0], nsync[7:0], npf[7:0]}, 0);
  endtask

  task automatic t_range;
    logic [31:0] v; int b = ncmd;
    wr(0, A_MODE, 32'h0000_8001);
    wr(0, A_START, 32'h0000_1000);
    wr(0, A_SIZE, 32'h0000_0200);
    rd(0, A_REGST, v); check("R3 range regstat", v, 0);
    idle(3);
    check("R3 range issued", ncmd - b, 1);
    check("R2 range op clean", {m_all[b], m_op[b], m_cpu[b]}, {1'b0, 2'd1, 1'b0});
    check("R3 range start", m_start[b], 32'h1000);
    check("R3 range size", m_size[b], 32'h200);
    for (int i = 0; i < 100; i++) begin
      rd(0, A_QST, v);
      if (v == 4) break;
    end
    check("R8 end flag exact", v, 4);
    rd(1, A_QST, v); check("R8 other cpu clean", v, 0);
    wr(0, A_QST, 32'h0000_0003);
    rd(0, A_QST, v); check("R8 other bits ignored", v, 4);
    wr(0, A_QST, 32'h0000_0004);
    rd(0, A_QST, v); check("R8 end flag cleared", v, 0);
  endtask

  task automatic t_all;
    logic [31:0] v; int b = ncmd;
    wr(1, A_MODE, 32'h0002_0002);
    rd(1, A_REGST, v); check("R3 all regstat", v, 0);
    idle(3);
    check("R3 all issued", ncmd - b, 1);
    check("R2 all flush", {m_all[b], m_op[b], m_cpu[b]}, {1'b1, 2'd2, 1'b1});
    check("R3 all zero fields", m_start[b] | m_size[b], 0);
    idle(LAT + 5);
    rd(1, A_QST, v); check("R8 no notify no flag", v, 0);
  endtask

  task automatic t_lock;
    logic [31:0] v; int b = ncmd;
    wr(0, A_MODE, 32'h0000_8000);
    wr(1, A_MODE, 32'h0002_0002);
    wr(1, A_SIZE, 32'h40);
    rd(1, A_REGST, v); check("R4 foreign fail", v, 1);
    wr(0, A_START, 32'h2000);
    wr(0, A_SIZE, 32'h80);
    rd(0, A_REGST, v); check("R4 owner ok", v, 0);
    idle(3);
    check("R4 one command", ncmd - b, 1);
    check("R4 owner command", {m_all[b], m_op[b], m_cpu[b]}, {1'b0, 2'd0, 1'b0});
    check("R4 owner size", m_size[b], 32'h80);
    idle(LAT + 5);
    wr(0, A_QST, 32'h4);
  endtask

  task automatic t_overrun;
    logic [31:0] v; int b = ncmd;
    wr(0, A_MODE, 32'h0000_0001);
    wr(0, A_START, 32'h3000);
    rd(0, A_REGST, v); check("R5 overrun fail", v, 1);
    rd(0, A_REGST, v); check("R5 read clears", v, 0);
    idle(3);
    check("R5 nothing issued", ncmd - b, 0);
    wr(1, A_MODE, 32'h0002_0000);
    rd(1, A_REGST, v); check("R4 lock released", v, 0);
    wr(0, A_MODE, 32'h0000_0003);
    rd(0, A_REGST, v); check("R2 bad op rejected", v, 1);
    wr(0, A_MODE, 32'h0004_0001);
    rd(0, A_REGST, v); check("R2 bad scope rejected", v, 1);
    idle(LAT + 5);
    check("R2 rejects not issued", ncmd - b, 1);
  endtask

  task automatic t_full;
    logic [31:0] v; int b = ncmd;
    for (int i = 0; i < 6; i++) begin
      wr(0, A_MODE, 32'h0002_0000 | (i % 3));
      rd(0, A_REGST, v);
      check(i < 5 ? "R6 accepted" : "R6 queue full", v, i < 5 ? 0 : 2);
    end
    rd(0, A_QST, v); check("R8 pending executing", v, 3);
    rd(1, A_QST, v); check("R8 other cpu idle", v, 0);
    idle(6 * (LAT + 1));
    check("R7 five issued", ncmd - b, 5);
    for (int i = 0; i < 5; i++) check("R7 order", m_op[b + i], i % 3);
    for (int i = 1; i < 5; i++) check("R7 spacing", m_cyc[b + i] - m_cyc[b + i - 1], LAT + 1);
  endtask

  task automatic t_prim;
    logic [31:0] v; int b = ncmd, s0 = nsync, p0 = npf;
    wr(1, A_MODE, 32'h0002_0001);
    rd(1, A_REGST, v);
    wr(1, A_MODE, 32'h0002_0002);
    rd(1, A_REGST, v);
    wr(0, A_PRIM, 32'h8);
    rd(0, A_PRIM, v); check("R9 drain pending", v, 1);
    check("R9 no early done", nsync - s0, 0);
    for (int i = 0; i < 200; i++) begin
      rd(0, A_PRIM, v);
      if (v == 0) break;
    end
    check("R9 drain finished", v, 0);
    check("R9 queue drained first", ncmd - b, 2);
    idle(LAT + 2);
    check("R9 one done pulse", nsync - s0, 1);
    wr(1, A_PRIM, 32'h9);
    idle(2);
    check("R9 prefetch pulse", npf - p0, 1);
    wr(1, A_PRIM, 32'h5);
    idle(3);
    rd(1, A_PRIM, v);
    check("R9 other code ignored", {v[7:0], 8'(npf - p0), 8'(nsync - s0)}, {8'd0, 8'd1, 8'd1});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_range;
    t_all;
    t_lock;
    t_overrun;
    idle(LAT + 5);
    t_full;
    t_prim;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule